// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block sits between a transmit word FIFO and the PHY-side data pins of an Ethernet MAC. It pops 32-bit payload words from a first-word-fall-through FIFO. It sends a fixed preamble and a start-of-frame delimiter ahead of the payload. It zero-fills short frames up to the minimum length and appends the inverted CRC-32 frame check sequence. The resulting byte stream goes out one byte per clock in gigabit mode, or one nibble per clock in 10/100 mode.

Each FIFO word carries a start marker, an end marker, a count of the valid bytes in the last word, and a flag that turns off the check sequence. When that flag is set, padding is turned off as well, so the frame leaves exactly as supplied. The FIFO must hold the next word of a frame by the time that word is needed. Mode changes are made only between frames. Interframe gap timing belongs to the surrounding controller, which starts counting on the done pulse.

Top module: `eth_tx_framer`

## Requirements
- R1: `tx_en` is high from the first preamble symbol through the final symbol of the frame, and low otherwise. While `tx_en` is low, `txd` is 0.
- R2: Every frame starts with seven 0x55 bytes followed by one 0xD5 byte, before any payload byte.
- R3: Payload words are sent byte by byte, bits [7:0] first and bits [31:24] last. One word is popped per four payload bytes, and `fifo_rd` is never high while `fifo_empty` is high.
- R4: In the word marked as the end of the frame, only the first `fifo_bytes` bytes are sent (0 means all four). The remaining bytes of that word never appear on `txd`.
- R5: When the check sequence is enabled and the payload is shorter than 60 bytes, zero bytes are appended until 60 bytes have been sent. A payload of 60 bytes or more gets no padding.
- R6: After the payload and padding come four check bytes. These are the bitwise inverse of a CRC-32 over payload and padding (polynomial 0x04C11DB7, register preset to all ones, data taken LSB first), sent least significant byte first.
- R7: When `fifo_nocrc` is set on the start word, the frame ends after its last payload byte, with neither padding nor check bytes.
- R8: With `gig_mode` high, one byte is driven per clock on all eight `txd` bits.
- R9: With `gig_mode` low, each byte takes two clocks on `txd[3:0]`, low nibble first, with `txd[7:4]` at 0.
- R10: `tx_done` is a single-cycle pulse in the cycle that carries the last symbol of a frame. `tx_en` drops for at least one cycle before a following frame starts.
- R11: While idle, a word at the FIFO head without the start marker is popped and discarded.
- R12: During and right after reset, `tx_en`, `txd`, `tx_done` and `fifo_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gig_mode | input | 1 | 1: byte-wide gigabit output; 0: nibble-wide 10/100 output |
| fifo_empty | input | 1 | FIFO has no word at its head |
| fifo_data | input | 32 | Word at the FIFO head |
| fifo_sof | input | 1 | Head word starts a frame |
| fifo_eof | input | 1 | Head word ends a frame |
| fifo_bytes | input | 2 | Valid bytes in an end word, 0 meaning four |
| fifo_nocrc | input | 1 | On the start word: skip padding and check bytes |
| fifo_rd | output | 1 | Pop the FIFO head word |
| txd | output | 8 | Symbol to the PHY |
| tx_en | output | 1 | Symbol on `txd` is part of a frame |
| tx_done | output | 1 | Last symbol of the frame is on `txd` |

## Verification
Two events can fall in the same cycle. The done pulse of one frame can coincide with the pop of the next frame's start word, and the last byte of a fetched word can coincide with the 60-byte decision that skips padding. The first case is set up by queuing two frames together. The bench then checks that both symbol streams match exactly and that `tx_en` rises exactly twice. The second case is set up with 59, 60 and 61-byte payloads. It is judged by the total symbol count and by the check bytes that the bench computes from its own bit-serial CRC model.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS
  } tx_state_e;

  localparam logic [7:0]  PRE_SYM      = 8'h55;
  localparam logic [7:0]  SFD_SYM      = 8'hD5;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;

  // One byte of reflected CRC-32, LSB of the data byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '1;
    end else if (clear) begin
      crc <= '1;
    end else if (en) begin
      crc <= crc32_step(crc, din);
    end
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PRE_LEN = 7,
  parameter int MIN_LEN = 60,
  parameter int FCS_LEN = 4,
  parameter int LEN_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fifo_empty,
  input  logic [DATA_W-1:0]               fifo_data,
  input  logic                            fifo_sof,
  input  logic                            fifo_eof,
  input  logic [$clog2(DATA_W/8)-1:0]     fifo_bytes,
  input  logic                            fifo_nocrc,
  output logic                            fifo_rd,
  input  logic                            adv,
  input  logic [31:0]                     crc,
  output logic                            active,
  output logic [7:0]                      sym_byte,
  output logic                            last_sym,
  output logic                            crc_clear,
  output logic                            crc_en
);

  localparam int BPW   = DATA_W / 8;
  localparam int BI_W  = $clog2(BPW);
  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam int FI_W  = $clog2(FCS_LEN);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_LEN - 1);
  localparam logic [BI_W-1:0]  BI_LAST  = BI_W'(BPW - 1);

  tx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [BI_W-1:0]    bi;
  logic [LEN_W-1:0]   len;
  logic [DATA_W-1:0]  wbuf;
  logic               weof;
  logic [BI_W-1:0]    wcnt;
  logic               nocrc_q;

  // Named internal events
  logic [BI_W-1:0]    last_idx;
  logic               last_data;
  logic               pad_needed;
  logic               word_fetch;
  logic [LEN_W-1:0]   len_inc;

  assign last_idx   = (wcnt == '0) ? BI_LAST : wcnt - 1'b1;
  assign last_data  = weof && (bi == last_idx);
  assign pad_needed = len < LEN_W'(MIN_LEN - 1);
  assign len_inc    = (len == '1) ? len : len + 1'b1;
  assign word_fetch = (state == ST_DATA) && adv && !last_data && (bi == BI_LAST);

  assign active    = (state != ST_IDLE);
  assign fifo_rd   = !fifo_empty && ((state == ST_IDLE) || word_fetch);
  assign crc_clear = (state == ST_IDLE);
  assign crc_en    = adv && ((state == ST_DATA) || (state == ST_PAD));
  assign last_sym  = ((state == ST_DATA) && last_data && nocrc_q) ||
                     ((state == ST_FCS) && (cnt == FCS_LAST));

  always_comb begin
    case (state)
      ST_PRE:  sym_byte = (cnt == PRE_LAST) ? SFD_SYM : PRE_SYM;
      ST_DATA: sym_byte = wbuf[8*bi +: 8];
      ST_FCS:  sym_byte = ~crc[8*cnt[FI_W-1:0] +: 8];
      default: sym_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bi      <= '0;
      len     <= '0;
      wbuf    <= '0;
      weof    <= 1'b0;
      wcnt    <= '0;
      nocrc_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!fifo_empty && fifo_sof) begin
            state   <= ST_PRE;
            cnt     <= '0;
            bi      <= '0;
            len     <= '0;
            wbuf    <= fifo_data;
            weof    <= fifo_eof;
            wcnt    <= fifo_bytes;
            nocrc_q <= fifo_nocrc;
          end
        end
        ST_PRE: begin
          if (adv) begin
            if (cnt == PRE_LAST) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (adv) begin
            len <= len_inc;
            if (last_data) begin
              bi <= '0;
              if (nocrc_q) begin
                state <= ST_IDLE;
              end else if (pad_needed) begin
                state <= ST_PAD;
              end else begin
                state <= ST_FCS;
                cnt   <= '0;
              end
            end else if (bi == BI_LAST) begin
              bi <= '0;
              if (fifo_rd) begin
                wbuf <= fifo_data;
                weof <= fifo_eof;
                wcnt <= fifo_bytes;
              end
            end else begin
              bi <= bi + 1'b1;
            end
          end
        end
        ST_PAD: begin
          if (adv) begin
            len <= len_inc;
            if (!pad_needed) begin
              state <= ST_FCS;
              cnt   <= '0;
            end
          end
        end
        ST_FCS: begin
          if (adv) begin
            if (cnt == FCS_LAST) begin
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: never pop an empty FIFO
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  // R2: payload only after the full preamble and delimiter
  a_r2_sfd_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_PRE) |-> $past(cnt) == PRE_LAST);

  // R5: padding only while below the minimum length
  a_r5_pad_short: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAD) |-> (len < LEN_W'(MIN_LEN)));

  // R7: suppressed frames never pad nor send check bytes
  a_r7_nocrc_path: assert property (@(posedge clk) disable iff (!rst_n)
    nocrc_q |-> (state != ST_PAD && state != ST_FCS));

  // R6: check sequence is exactly four bytes long
  a_r6_fcs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCS) |-> (cnt <= FCS_LAST));

endmodule

// File: rtl/eth_tx_serdes.sv
module eth_tx_serdes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gig_mode,
  input  logic       active,
  input  logic       last_sym,
  input  logic [7:0] sym_byte,
  output logic       adv,
  output logic [7:0] txd,
  output logic       tx_en,
  output logic       tx_done
);

  logic phase_q;
  logic nib_mode_q;

  // A byte is consumed every clock in gigabit mode, every second in 10/100.
  assign adv = active && (gig_mode || phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      txd        <= '0;
      tx_en      <= 1'b0;
      tx_done    <= 1'b0;
      nib_mode_q <= 1'b0;
    end else begin
      phase_q    <= (active && !gig_mode) ? ~phase_q : 1'b0;
      tx_en      <= active;
      tx_done    <= adv && last_sym;
      nib_mode_q <= !gig_mode;
      if (!active) begin
        txd <= '0;
      end else if (gig_mode) begin
        txd <= sym_byte;
      end else begin
        txd <= {4'h0, phase_q ? sym_byte[7:4] : sym_byte[3:0]};
      end
    end
  end

  // R1: quiet bus outside a frame
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 8'h00));

  // R9: upper lines stay low in nibble mode
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && nib_mode_q) |-> (txd[7:4] == 4'h0));

  // R10: done marks a symbol inside the frame
  a_r10_done_inside: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_en);

  // R10: the frame closes right after done
  a_r10_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_en);

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PRE_LEN = 7,
  parameter int MIN_LEN = 60,
  parameter int FCS_LEN = 4,
  parameter int LEN_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gig_mode,
  input  logic                        fifo_empty,
  input  logic [DATA_W-1:0]           fifo_data,
  input  logic                        fifo_sof,
  input  logic                        fifo_eof,
  input  logic [$clog2(DATA_W/8)-1:0] fifo_bytes,
  input  logic                        fifo_nocrc,
  output logic                        fifo_rd,
  output logic [7:0]                  txd,
  output logic                        tx_en,
  output logic                        tx_done
);

  logic        adv;
  logic        active;
  logic        last_sym;
  logic        crc_clear;
  logic        crc_en;
  logic [7:0]  sym_byte;
  logic [31:0] crc;

  eth_tx_seq #(
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN),
    .MIN_LEN(MIN_LEN),
    .FCS_LEN(FCS_LEN),
    .LEN_W  (LEN_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(fifo_empty),
    .fifo_data (fifo_data),
    .fifo_sof  (fifo_sof),
    .fifo_eof  (fifo_eof),
    .fifo_bytes(fifo_bytes),
    .fifo_nocrc(fifo_nocrc),
    .fifo_rd   (fifo_rd),
    .adv       (adv),
    .crc       (crc),
    .active    (active),
    .sym_byte  (sym_byte),
    .last_sym  (last_sym),
    .crc_clear (crc_clear),
    .crc_en    (crc_en)
  );

  eth_tx_crc crc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(crc_clear),
    .en   (crc_en),
    .din  (sym_byte),
    .crc  (crc)
  );

  eth_tx_serdes serdes_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .gig_mode(gig_mode),
    .active  (active),
    .last_sym(last_sym),
    .sym_byte(sym_byte),
    .adv     (adv),
    .txd     (txd),
    .tx_en   (tx_en),
    .tx_done (tx_done)
  );

endmodule

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gig_mode = 1'b1;
  logic        fifo_empty;
  logic [31:0] fifo_data;
  logic        fifo_sof, fifo_eof, fifo_nocrc;
  logic [1:0]  fifo_bytes;
  logic        fifo_rd;
  logic [7:0]  txd;
  logic        tx_en, tx_done;

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  // FIFO model
  logic [31:0] fq_data  [0:1023];
  logic        fq_sof   [0:1023];
  logic        fq_eof   [0:1023];
  logic        fq_nocrc [0:1023];
  logic [1:0]  fq_bytes [0:1023];
  int head = 0;
  int tail = 0;

  assign fifo_empty = (head == tail);
  assign fifo_data  = fq_data[head];
  assign fifo_sof   = fq_sof[head];
  assign fifo_eof   = fq_eof[head];
  assign fifo_nocrc = fq_nocrc[head];
  assign fifo_bytes = fq_bytes[head];

  always @(posedge clk) if (fifo_rd) head <= head + 1;

  eth_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_sof(fifo_sof),
    .fifo_eof(fifo_eof), .fifo_bytes(fifo_bytes), .fifo_nocrc(fifo_nocrc),
    .fifo_rd(fifo_rd), .txd(txd), .tx_en(tx_en), .tx_done(tx_done)
  );

  // Monitor, sampling away from the active edge
  logic [7:0] cap [0:2047];
  int cap_n = 0;
  int done_n = 0;
  int last_done_pos = -1;
  int rise_n = 0;
  int idle_bad = 0;
  logic en_prev = 1'b0;

  always @(negedge clk) begin
    if (tx_done) begin
      last_done_pos = cap_n;
      done_n++;
    end
    if (tx_en) begin
      if (cap_n < 2048) cap[cap_n] = txd;
      cap_n++;
      if (!en_prev) rise_n++;
    end else if (txd != 8'h00) begin
      idle_bad++;
    end
    en_prev = tx_en;
  end

  // Expected stream
  logic [7:0] exp_s [0:2047];
  int exp_n = 0;
  logic [7:0] fb [0:255];

  // Stimulus table: {payload length, seed, 6'b0, no-check flag, gigabit}
  localparam int NV = 11;
  localparam logic [31:0] VECS [0:NV-1] = '{
    {16'd1,   8'h11, 6'd0, 1'b0, 1'b1},  // R4 R5: one byte, heavy padding
    {16'd14,  8'h22, 6'd0, 1'b0, 1'b1},  // R4 R5
    {16'd59,  8'h33, 6'd0, 1'b0, 1'b1},  // R5: one pad byte
    {16'd60,  8'h44, 6'd0, 1'b0, 1'b1},  // R5 R6: exactly minimum
    {16'd61,  8'h55, 6'd0, 1'b0, 1'b1},  // R4 R6
    {16'd100, 8'h66, 6'd0, 1'b0, 1'b1},  // R3 R8
    {16'd10,  8'h77, 6'd0, 1'b1, 1'b1},  // R7: short, no pad
    {16'd20,  8'h88, 6'd0, 1'b1, 1'b0},  // R7 R9
    {16'd33,  8'h99, 6'd0, 1'b0, 1'b0},  // R9 R4
    {16'd64,  8'hA5, 6'd0, 1'b0, 1'b0},  // R9 R6
    {16'd3,   8'h5A, 6'd0, 1'b0, 1'b0}   // R9 R5
  };

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 3) & 255);
  endfunction

  // Bit-serial MSB-register form of the check, reflected at the end.
  function automatic logic [31:0] ref_fcs(input int nb);
    logic [31:0] c;
    logic [31:0] r;
    logic fbk;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < 8; j++) begin
        fbk = c[31] ^ fb[k][j];
        c = {c[30:0], 1'b0};
        if (fbk) c = c ^ 32'h04C11DB7;
      end
    end
    for (int j = 0; j < 32; j++) r[j] = ~c[31-j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic put_sym(input logic [7:0] b, input bit gig);
    if (gig) begin
      exp_s[exp_n] = b; exp_n++;
    end else begin
      exp_s[exp_n] = {4'h0, b[3:0]}; exp_n++;
      exp_s[exp_n] = {4'h0, b[7:4]}; exp_n++;
    end
  endtask

  task automatic push_word(input logic [31:0] d, input bit s, input bit e, input logic [1:0] nb, input bit nc);
    fq_data[tail] = d; fq_sof[tail] = s; fq_eof[tail] = e;
    fq_bytes[tail] = nb; fq_nocrc[tail] = nc;
    tail++;
  endtask

  task automatic add_frame(input int len, input int seed, input bit nocrc, input bit gig);
    int nb;
    int nw;
    logic [31:0] fcs;
    logic [31:0] wd;
    nb = 0;
    fcs = '0;
    for (int i = 0; i < len; i++) begin fb[nb] = pbyte(seed, i); nb++; end
    if (!nocrc) begin
      while (nb < 60) begin fb[nb] = 8'h00; nb++; end
      fcs = ref_fcs(nb);
    end
    for (int i = 0; i < 7; i++) put_sym(8'h55, gig);
    put_sym(8'hD5, gig);
    for (int i = 0; i < nb; i++) put_sym(fb[i], gig);
    if (!nocrc) for (int k = 0; k < 4; k++) put_sym(fcs[8*k +: 8], gig);
    nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      for (int k = 0; k < 4; k++)
        wd[8*k +: 8] = (w*4 + k < len) ? pbyte(seed, w*4 + k) : 8'hAA;
      push_word(wd, w == 0, w == nw - 1, 2'(len % 4), nocrc);
    end
  endtask

  task automatic wait_and_compare(input int base_c, input int base_d, input int base_r,
                                  input int nframes, input string tag);
    int t;
    int bad;
    int bad_i;
    t = 0;
    while (done_n < base_d + nframes && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(cap_n - base_c == exp_n, tag, "symbol count", cap_n - base_c, exp_n);
    bad = 0; bad_i = 0;
    for (int i = 0; i < exp_n && i < cap_n - base_c; i++) begin
      if (cap[base_c + i] !== exp_s[i]) begin
        if (bad == 0) bad_i = i;
        bad++;
      end
    end
    if (bad != 0)
      $display("  first symbol mismatch at %0d: actual %0h expected %0h",
               bad_i, cap[base_c + bad_i], exp_s[bad_i]);
    chk(bad == 0, tag, "symbol content mismatches", bad, 0);
    chk(done_n - base_d == nframes, "R10", "done pulses", done_n - base_d, nframes);
    chk(last_done_pos - base_c == exp_n - 1, "R10", "done position", last_done_pos - base_c, exp_n - 1);
    chk(rise_n - base_r == nframes, "R1 R10", "tx_en bursts", rise_n - base_r, nframes);
  endtask

  // Watchdog
  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bc, bd, br;
    for (int i = 0; i < 1024; i++) begin
      fq_data[i] = '0; fq_sof[i] = 1'b0; fq_eof[i] = 1'b0;
      fq_bytes[i] = '0; fq_nocrc[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(tx_en == 1'b0, "R12", "tx_en in reset", int'(tx_en), 0);
    chk(txd == 8'h00, "R12", "txd in reset", int'(txd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_done == 1'b0, "R12", "tx_done after reset", int'(tx_done), 0);
    chk(fifo_rd == 1'b0, "R12", "fifo_rd after reset", int'(fifo_rd), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      bc = cap_n; bd = done_n; br = rise_n;
      exp_n = 0;
      gig_mode = VECS[v][0];
      add_frame(int'(VECS[v][31:16]), int'(VECS[v][15:8]), VECS[v][1], VECS[v][0]);
      wait_and_compare(bc, bd, br, 1, "R2 R3 R4 R5 R6 R7 R8 R9 table");
    end

    // R11: stray word without start marker is dropped
    bc = cap_n; bd = done_n; br = rise_n;
    exp_n = 0;
    gig_mode = 1'b1;
    push_word(32'hDEADBEEF, 1'b0, 1'b1, 2'd0, 1'b0);
    add_frame(12, 8'h3C, 1'b0, 1'b1);
    wait_and_compare(bc, bd, br, 1, "R11");
    chk(head == tail, "R11", "words left in FIFO", tail - head, 0);

    // R10: back-to-back frames, done coinciding with next start pop
    bc = cap_n; bd = done_n; br = rise_n;
    exp_n = 0;
    gig_mode = 1'b1;
    add_frame(8, 8'h21, 1'b0, 1'b1);
    add_frame(5, 8'h43, 1'b1, 1'b1);
    wait_and_compare(bc, bd, br, 2, "R10 back-to-back");

    // R1: bus quiet between frames
    chk(idle_bad == 0, "R1", "nonzero txd while idle", idle_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule